// File: doc/BRIEF.md
# Vector Mask Conditionalization Unit

This block keeps a per-element mask for one lane of a vector engine. For each vector statement it decides which elements may write back an arithmetic result and which may touch memory. The block also produces a merge select for two-way selects and a count of the active mask bits. The issuing logic presents one operation per cycle. The operation carries a mask mode, a sense-invert flag, a rotate flag, a scalar flag and a vector length. The block answers one clock later with registered enable vectors.

The mask is written from several sources. The first is per-element compare flags run through a relation selector. The second is a direct load port, which can fire in the same cycle as an operation. The third is a restore from a private save buffer. A default mode register serves every operation that asks for the default. Sticky mode writes and a dedicated set-mode operation update it. The arithmetic, compare and memory datapaths sit outside this block.

Top module: `vmask_unit`

## Requirements
- R1: After reset the mask and the save buffer are all ones and the default mode is always (4). `res_valid`, `alu_en`, `mem_en`, `merge_sel` and `ones_cnt` are zero until an operation produces a result.
- R2: A use operation (kind 1) drives its outputs one cycle after issue. The resolved mode gates them as follows. Full (1) gates both `alu_en` and `mem_en` with the effective mask. ALU (2) gates only `alu_en`, and `mem_en` equals the length mask. Memory (3) gates only `mem_en`, and `alu_en` equals the length mask. Always (4) sets both to the length mask.
- R3: Mode 0 selects the stored default. A use operation with `op_sticky` set and a mode from 1 to 4 also stores that mode as the default. Set-mode (kind 6) stores the mode without producing a result. A non-sticky use leaves the default unchanged.
- R4: `merge_sel` equals the effective mask. A 1 selects the first source.
- R5: With `op_invert` set, the effective mask is the complement of the stored mask within the length.
- R6: Elements at and above the effective length read as zero in `alu_en`, `mem_en` and `merge_sel`, and `ones_cnt` ignores them. A length above 16 is treated as 16. A length of 0 enables nothing.
- R7: `ones_cnt` is the number of ones in the effective mask. It is produced by use and by count (kind 3). Count leaves the enables at zero. `op_scalar` sets the effective length to 1.
- R8: A use operation with `op_rotate` set rotates the mask right by its effective length. Bit 0 moves to the top. A use without rotate leaves the mask unchanged.
- R9: A compare operation (kind 2) replaces the mask bits below the effective length with the chosen relation and keeps the bits above it. The relation codes are: 0 greater, 1 equal, 2 less, 3 greater-or-equal, 4 unordered, 5 ordered-and-not-equal (greater or less), 6 not-equal-or-unordered (not equal), 7 less-or-equal.
- R10: `ld_valid` writes `ld_data` into the mask, and `mask_out` shows it the next cycle. An operation in the same cycle sees the old mask. The load also overrides any rotate, compare or restore write in that cycle.
- R11: Save (kind 4) copies the mask into the buffer. Restore (kind 5) copies the buffer back into the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_kind | input | 3 | Operation kind |
| op_mode | input | 3 | Mask mode, 0 = default |
| op_sticky | input | 1 | Store the mode as the default |
| op_invert | input | 1 | Invert the mask sense |
| op_rotate | input | 1 | Rotate the mask after a use |
| op_scalar | input | 1 | Scalar variant, length 1 |
| op_vlen | input | 5 | Vector length |
| cmp_rel | input | 3 | Compare relation code |
| cmp_gt | input | 16 | Per-element greater flag |
| cmp_eq | input | 16 | Per-element equal flag |
| cmp_lt | input | 16 | Per-element less flag |
| cmp_un | input | 16 | Per-element unordered flag |
| ld_valid | input | 1 | Mask load strobe |
| ld_data | input | 16 | Mask load value |
| mask_out | output | 16 | Current mask, for storing to a data register |
| res_valid | output | 1 | Result outputs valid |
| alu_en | output | 16 | Per-element write-back enable |
| mem_en | output | 16 | Per-element memory enable |
| merge_sel | output | 16 | Per-element merge select |
| ones_cnt | output | 5 | Count of active mask bits |

## Verification
The hardest case to reach is a mask load and a mask-consuming operation in the same cycle. This is worst when the operation would also rotate the mask, because three writers then meet on one edge. The bench drives the load strobe and a rotating use on the same falling edge. It then checks that the enables reflect the mask from before the edge and that `mask_out` holds the loaded value unrotated. Sticky mode persistence is reached by chaining a sticky use, a plain use and a default-mode use, so that only the last one shows the stored default.

// File: rtl/vmask_pkg.sv
package vmask_pkg;
  typedef enum logic [2:0] {
    MM_DEFAULT = 3'd0, MM_FULL = 3'd1, MM_ALU = 3'd2, MM_MEM = 3'd3, MM_ALWAYS = 3'd4
  } mmode_e;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_USE = 3'd1, OP_CMP = 3'd2, OP_COUNT = 3'd3,
    OP_SAVE = 3'd4, OP_RESTORE = 3'd5, OP_SETMODE = 3'd6
  } opkind_e;

  typedef enum logic [2:0] {
    REL_GT = 3'd0, REL_EQ = 3'd1, REL_LT = 3'd2, REL_GE = 3'd3,
    REL_UN = 3'd4, REL_LG = 3'd5, REL_NE = 3'd6, REL_LE = 3'd7
  } rel_e;
endpackage

// File: rtl/vmask_relsel.sv
module vmask_relsel
  import vmask_pkg::*;
#(
  parameter int W = 16
) (
  input  rel_e         rel,
  input  logic [W-1:0] gt,
  input  logic [W-1:0] eq,
  input  logic [W-1:0] lt,
  input  logic [W-1:0] un,
  output logic [W-1:0] hit
);
  always_comb begin
    case (rel)
      REL_GT:  hit = gt;
      REL_EQ:  hit = eq;
      REL_LT:  hit = lt;
      REL_GE:  hit = gt | eq;
      REL_UN:  hit = un;
      REL_LG:  hit = gt | lt;
      REL_NE:  hit = ~eq;
      default: hit = lt | eq;
    endcase
  end
endmodule

// File: rtl/vmask_state.sv
module vmask_state
  import vmask_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  opkind_e          op_kind,
  input  mmode_e           op_mode,
  input  logic             op_sticky,
  input  logic             rot_en,
  input  logic [LEN_W-1:0] rot_amt,
  input  logic [W-1:0]     cmp_hit,
  input  logic [W-1:0]     len_mask,
  input  logic             ld_valid,
  input  logic [W-1:0]     ld_data,
  output logic [W-1:0]     mask_q,
  output mmode_e           dflt_q
);
  logic [W-1:0] buf_q, rot_v, mask_nxt;
  logic [LEN_W-1:0] amt;
  logic do_cmp, do_restore, do_save, dflt_we, mode_ok;

  assign do_cmp     = op_valid && op_kind == OP_CMP;
  assign do_restore = op_valid && op_kind == OP_RESTORE;
  assign do_save    = op_valid && op_kind == OP_SAVE;
  assign mode_ok    = op_mode != MM_DEFAULT && op_mode <= MM_ALWAYS;
  assign dflt_we    = op_valid && mode_ok &&
                      (op_kind == OP_SETMODE || (op_kind == OP_USE && op_sticky));
  assign amt        = (rot_amt >= LEN_W'(W)) ? '0 : rot_amt;

  always_comb begin
    for (int i = 0; i < W; i++) rot_v[i] = mask_q[(i + int'(amt)) % W];
  end

  always_comb begin
    if (ld_valid)        mask_nxt = ld_data;
    else if (do_restore) mask_nxt = buf_q;
    else if (do_cmp)     mask_nxt = (cmp_hit & len_mask) | (mask_q & ~len_mask);
    else if (rot_en)     mask_nxt = rot_v;
    else                 mask_nxt = mask_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '1;
      buf_q  <= '1;
      dflt_q <= MM_ALWAYS;
    end else begin
      mask_q <= mask_nxt;
      if (do_save) buf_q <= mask_q;
      if (dflt_we) dflt_q <= op_mode;
    end
  end

  // R10
  load_take_chk: assert property (@(posedge clk) disable iff (rst)
    $past(ld_valid) |-> mask_q == $past(ld_data));
  // R11
  restore_chk: assert property (@(posedge clk) disable iff (rst)
    $past(do_restore && !ld_valid) |-> mask_q == $past(buf_q));
  // R8
  rot_keep_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rot_en && !ld_valid && !do_restore && !do_cmp) |->
      $countones(mask_q) == $countones($past(mask_q)));
  // R9
  cmp_upper_chk: assert property (@(posedge clk) disable iff (rst)
    $past(do_cmp && !ld_valid) |-> ((mask_q ^ $past(mask_q)) & ~$past(len_mask)) == '0);
  // R3
  dflt_legal_chk: assert property (@(posedge clk) disable iff (rst)
    dflt_q != MM_DEFAULT && dflt_q <= MM_ALWAYS);
endmodule

// File: rtl/vmask_gate.sv
module vmask_gate
  import vmask_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire_use,
  input  logic             fire_cnt,
  input  logic [W-1:0]     mask_q,
  input  logic             invert,
  input  logic [W-1:0]     len_mask,
  input  mmode_e           mode,
  output logic             res_valid,
  output logic [W-1:0]     alu_en,
  output logic [W-1:0]     mem_en,
  output logic [W-1:0]     merge_sel,
  output logic [CNT_W-1:0] ones_cnt
);
  logic [W-1:0] eff, alu_d, mem_d;
  logic [CNT_W-1:0] cnt_d;
  logic res_use_q;

  assign eff = (mask_q ^ {W{invert}}) & len_mask;

  always_comb begin
    cnt_d = '0;
    for (int i = 0; i < W; i++) cnt_d = cnt_d + CNT_W'(eff[i]);
  end

  always_comb begin
    case (mode)
      MM_FULL: begin alu_d = eff;      mem_d = eff;      end
      MM_ALU:  begin alu_d = eff;      mem_d = len_mask; end
      MM_MEM:  begin alu_d = len_mask; mem_d = eff;      end
      default: begin alu_d = len_mask; mem_d = len_mask; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid <= 1'b0;
      res_use_q <= 1'b0;
      alu_en    <= '0;
      mem_en    <= '0;
      merge_sel <= '0;
      ones_cnt  <= '0;
    end else begin
      res_valid <= fire_use || fire_cnt;
      res_use_q <= fire_use;
      alu_en    <= fire_use ? alu_d : '0;
      mem_en    <= fire_use ? mem_d : '0;
      merge_sel <= fire_use ? eff : '0;
      ones_cnt  <= (fire_use || fire_cnt) ? cnt_d : '0;
    end
  end

  // R2
  mode_nest_chk: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ((alu_en & ~mem_en) == '0 || (mem_en & ~alu_en) == '0));
  // R4
  merge_inside_chk: assert property (@(posedge clk) disable iff (rst)
    (merge_sel & ~(alu_en | mem_en)) == '0);
  // R7
  cnt_match_chk: assert property (@(posedge clk) disable iff (rst)
    res_use_q |-> ones_cnt == CNT_W'($countones(merge_sel)));
  // R1
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (alu_en == '0 && mem_en == '0 && ones_cnt == '0));
endmodule

// File: rtl/vmask_unit.sv
module vmask_unit
  import vmask_pkg::*;
#(
  parameter int W     = 16,
  parameter int LEN_W = $clog2(W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [2:0]       op_kind,
  input  logic [2:0]       op_mode,
  input  logic             op_sticky,
  input  logic             op_invert,
  input  logic             op_rotate,
  input  logic             op_scalar,
  input  logic [LEN_W-1:0] op_vlen,
  input  logic [2:0]       cmp_rel,
  input  logic [W-1:0]     cmp_gt,
  input  logic [W-1:0]     cmp_eq,
  input  logic [W-1:0]     cmp_lt,
  input  logic [W-1:0]     cmp_un,
  input  logic             ld_valid,
  input  logic [W-1:0]     ld_data,
  output logic [W-1:0]     mask_out,
  output logic             res_valid,
  output logic [W-1:0]     alu_en,
  output logic [W-1:0]     mem_en,
  output logic [W-1:0]     merge_sel,
  output logic [LEN_W-1:0] ones_cnt
);
  opkind_e kind;
  mmode_e  mode_in, dflt, res_mode;
  logic [LEN_W-1:0] eff_len;
  logic [W-1:0] len_mask, hit;
  logic fire_use, fire_cnt;

  assign kind     = opkind_e'(op_kind);
  assign mode_in  = mmode_e'(op_mode);
  assign res_mode = (mode_in == MM_DEFAULT) ? dflt : mode_in;
  assign fire_use = op_valid && kind == OP_USE;
  assign fire_cnt = op_valid && kind == OP_COUNT;

  always_comb begin
    if (op_scalar)                 eff_len = LEN_W'(1);
    else if (op_vlen > LEN_W'(W))  eff_len = LEN_W'(W);
    else                           eff_len = op_vlen;
  end

  always_comb begin
    for (int i = 0; i < W; i++) len_mask[i] = LEN_W'(i) < eff_len;
  end

  vmask_relsel #(.W(W)) u_rel (
    .rel(rel_e'(cmp_rel)), .gt(cmp_gt), .eq(cmp_eq), .lt(cmp_lt), .un(cmp_un), .hit(hit)
  );

  vmask_state #(.W(W), .LEN_W(LEN_W)) u_state (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(kind), .op_mode(mode_in),
    .op_sticky(op_sticky), .rot_en(fire_use && op_rotate), .rot_amt(eff_len),
    .cmp_hit(hit), .len_mask(len_mask), .ld_valid(ld_valid), .ld_data(ld_data),
    .mask_q(mask_out), .dflt_q(dflt)
  );

  vmask_gate #(.W(W), .CNT_W(LEN_W)) u_gate (
    .clk(clk), .rst(rst), .fire_use(fire_use), .fire_cnt(fire_cnt), .mask_q(mask_out),
    .invert(op_invert), .len_mask(len_mask), .mode(res_mode), .res_valid(res_valid),
    .alu_en(alu_en), .mem_en(mem_en), .merge_sel(merge_sel), .ones_cnt(ones_cnt)
  );
endmodule

// File: tb/vmask_unit_tb.sv
module vmask_unit_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic op_valid = 0, op_sticky = 0, op_invert = 0, op_rotate = 0, op_scalar = 0;
  logic [2:0] op_kind = 0, op_mode = 0, cmp_rel = 0;
  logic [4:0] op_vlen = 0;
  logic [15:0] cmp_gt = 0, cmp_eq = 0, cmp_lt = 0, cmp_un = 0;
  logic ld_valid = 0;
  logic [15:0] ld_data = 0;
  logic [15:0] mask_out, alu_en, mem_en, merge_sel;
  logic res_valid;
  logic [4:0] ones_cnt;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vmask_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .op_mode(op_mode),
    .op_sticky(op_sticky), .op_invert(op_invert), .op_rotate(op_rotate),
    .op_scalar(op_scalar), .op_vlen(op_vlen), .cmp_rel(cmp_rel), .cmp_gt(cmp_gt),
    .cmp_eq(cmp_eq), .cmp_lt(cmp_lt), .cmp_un(cmp_un), .ld_valid(ld_valid),
    .ld_data(ld_data), .mask_out(mask_out), .res_valid(res_valid), .alu_en(alu_en),
    .mem_en(mem_en), .merge_sel(merge_sel), .ones_cnt(ones_cnt)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Drive one operation on a falling edge, return on the next falling edge.
  task automatic issue(input logic [2:0] kind, input logic [2:0] mode, input logic sticky,
                       input logic inv, input logic rot, input logic scal,
                       input logic [4:0] vlen, input logic ldv, input logic [15:0] ldd);
    @(negedge clk);
    op_valid = (kind != 3'd0); op_kind = kind; op_mode = mode; op_sticky = sticky;
    op_invert = inv; op_rotate = rot; op_scalar = scal; op_vlen = vlen;
    ld_valid = ldv; ld_data = ldd;
    @(negedge clk);
    op_valid = 0; op_kind = 0; op_sticky = 0; op_invert = 0; op_rotate = 0;
    op_scalar = 0; ld_valid = 0;
  endtask

  task automatic load(input logic [15:0] d);
    issue(3'd0, 3'd0, 0, 0, 0, 0, 5'd0, 1'b1, d);
  endtask

  task automatic use_chk(input string req, input logic [15:0] ea, input logic [15:0] em,
                         input logic [15:0] es, input logic [4:0] ec);
    chk(req, "res_valid", 32'(res_valid), 32'd1);
    chk(req, "alu_en", 32'(alu_en), 32'(ea));
    chk(req, "mem_en", 32'(mem_en), 32'(em));
    chk(req, "merge_sel", 32'(merge_sel), 32'(es));
    chk(req, "ones_cnt", 32'(ones_cnt), 32'(ec));
  endtask

  task automatic t_reset;
    chk("R1", "mask_out", 32'(mask_out), 32'hFFFF);
    chk("R1", "res_valid", 32'(res_valid), 32'd0);
    chk("R1", "alu_en", 32'(alu_en), 32'd0);
    chk("R1", "ones_cnt", 32'(ones_cnt), 32'd0);
    // R1: default mode is always -> length mask on both
    load(16'h00F5);
    issue(3'd1, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    use_chk("R1", 16'h00FF, 16'h00FF, 16'h00F5, 5'd6);
  endtask

  task automatic t_modes;
    issue(3'd1, 3'd1, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    use_chk("R2", 16'h00F5, 16'h00F5, 16'h00F5, 5'd6);
    issue(3'd1, 3'd2, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    use_chk("R2", 16'h00F5, 16'h00FF, 16'h00F5, 5'd6);
    issue(3'd1, 3'd3, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    use_chk("R2", 16'h00FF, 16'h00F5, 16'h00F5, 5'd6);
    issue(3'd1, 3'd4, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    use_chk("R2", 16'h00FF, 16'h00FF, 16'h00F5, 5'd6);
  endtask

  task automatic t_default;
    issue(3'd1, 3'd2, 0, 0, 0, 0, 5'd8, 0, 16'h0);  // non-sticky ALU
    issue(3'd1, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    use_chk("R3", 16'h00FF, 16'h00FF, 16'h00F5, 5'd6);
    issue(3'd1, 3'd3, 1, 0, 0, 0, 5'd8, 0, 16'h0);  // sticky memory
    use_chk("R3", 16'h00FF, 16'h00F5, 16'h00F5, 5'd6);
    issue(3'd1, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    use_chk("R3", 16'h00FF, 16'h00F5, 16'h00F5, 5'd6);
    issue(3'd6, 3'd1, 0, 0, 0, 0, 5'd8, 0, 16'h0);  // set-mode full
    chk("R3", "setmode res_valid", 32'(res_valid), 32'd0);
    issue(3'd1, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    use_chk("R3", 16'h00F5, 16'h00F5, 16'h00F5, 5'd6);
  endtask

  task automatic t_merge_invert;
    issue(3'd1, 3'd1, 0, 0, 0, 0, 5'd16, 0, 16'h0);
    use_chk("R4", 16'h00F5, 16'h00F5, 16'h00F5, 5'd6);
    issue(3'd1, 3'd1, 0, 1, 0, 0, 5'd16, 0, 16'h0);
    use_chk("R5", 16'hFF0A, 16'hFF0A, 16'hFF0A, 5'd10);
  endtask

  task automatic t_vlen;
    issue(3'd1, 3'd4, 0, 0, 0, 0, 5'd4, 0, 16'h0);
    use_chk("R6", 16'h000F, 16'h000F, 16'h0005, 5'd2);
    issue(3'd1, 3'd4, 0, 0, 0, 0, 5'd0, 0, 16'h0);
    use_chk("R6", 16'h0000, 16'h0000, 16'h0000, 5'd0);
    issue(3'd1, 3'd4, 0, 0, 0, 0, 5'd20, 0, 16'h0);
    use_chk("R6", 16'hFFFF, 16'hFFFF, 16'h00F5, 5'd6);
  endtask

  task automatic t_count;
    issue(3'd3, 3'd1, 0, 0, 0, 0, 5'd16, 0, 16'h0);
    use_chk("R7", 16'h0000, 16'h0000, 16'h0000, 5'd6);
    issue(3'd1, 3'd1, 0, 0, 0, 1, 5'd16, 0, 16'h0);
    use_chk("R7", 16'h0001, 16'h0001, 16'h0001, 5'd1);
    issue(3'd3, 3'd1, 0, 1, 0, 1, 5'd16, 0, 16'h0);
    use_chk("R7", 16'h0000, 16'h0000, 16'h0000, 5'd0);
  endtask

  task automatic t_rotate;
    issue(3'd1, 3'd1, 0, 0, 0, 0, 5'd4, 0, 16'h0);
    chk("R8", "no rotate mask", 32'(mask_out), 32'h00F5);
    issue(3'd1, 3'd1, 0, 0, 1, 0, 5'd4, 0, 16'h0);
    chk("R8", "rotate by 4", 32'(mask_out), 32'h500F);
    issue(3'd1, 3'd1, 0, 0, 1, 1, 5'd9, 0, 16'h0);
    chk("R8", "scalar rotate by 1", 32'(mask_out), 32'hA807);
    issue(3'd1, 3'd1, 0, 0, 1, 0, 5'd16, 0, 16'h0);
    chk("R8", "rotate by 16", 32'(mask_out), 32'hA807);
  endtask

  task automatic t_compare;
    cmp_gt = 16'hFF03; cmp_eq = 16'h000C; cmp_lt = 16'h0030; cmp_un = 16'h00C0;
    load(16'h0000);
    cmp_rel = 3'd0; issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    chk("R9", "gt vlen8", 32'(mask_out), 32'h0003);
    issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd16, 0, 16'h0);
    chk("R9", "gt vlen16", 32'(mask_out), 32'hFF03);
    cmp_rel = 3'd1; issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    chk("R9", "eq", 32'(mask_out), 32'hFF0C);
    cmp_rel = 3'd2; issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    chk("R9", "lt", 32'(mask_out), 32'hFF30);
    cmp_rel = 3'd3; issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    chk("R9", "ge", 32'(mask_out), 32'hFF0F);
    cmp_rel = 3'd4; issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    chk("R9", "un", 32'(mask_out), 32'hFFC0);
    cmp_rel = 3'd5; issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    chk("R9", "lg", 32'(mask_out), 32'hFF33);
    cmp_rel = 3'd6; issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    chk("R9", "ne", 32'(mask_out), 32'hFFF3);
    cmp_rel = 3'd7; issue(3'd2, 3'd0, 0, 0, 0, 0, 5'd8, 0, 16'h0);
    chk("R9", "le", 32'(mask_out), 32'hFF3C);
  endtask

  task automatic t_collision;
    load(16'h00F5);
    issue(3'd1, 3'd1, 0, 0, 0, 0, 5'd16, 1'b1, 16'h0F00);
    use_chk("R10", 16'h00F5, 16'h00F5, 16'h00F5, 5'd6);
    chk("R10", "mask after load", 32'(mask_out), 32'h0F00);
    issue(3'd1, 3'd1, 0, 0, 1, 0, 5'd4, 1'b1, 16'h1234);
    chk("R10", "load beats rotate", 32'(mask_out), 32'h1234);
    chk("R10", "use saw old mask", 32'(merge_sel), 32'h0000);
  endtask

  task automatic t_save_restore;
    issue(3'd4, 3'd0, 0, 0, 0, 0, 5'd0, 0, 16'h0);
    load(16'hABCD);
    chk("R11", "mask before restore", 32'(mask_out), 32'hABCD);
    issue(3'd5, 3'd0, 0, 0, 0, 0, 5'd0, 0, 16'h0);
    chk("R11", "mask restored", 32'(mask_out), 32'h1234);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_modes();
    t_default();
    t_merge_invert();
    t_vlen();
    t_count();
    t_rotate();
    t_compare();
    t_collision();
    t_save_restore();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule